// File: doc/BRIEF.md
# Video Capture Stream Status Tagger

This block sits on the write side of a video capture FIFO. It takes a stream of pixel bytes and packs them into 32-bit words. Each word gets a 4-bit status code that tells the reader where scan lines, fields and format changes fall. The result is written as 36-bit entries into three lanes. In packed format every byte goes to lane 0. In planar format the bytes are split into luma and two chroma lanes.

The reader never sees the timing strobes, so the block also writes control entries that carry zero data:

- A format indicator at the start of every capture-enabled field.
- A format indicator when capture is switched on partway through a field.
- A format indicator when the effective format changes, for example when a VBI line is captured in packed form.
- A field-end marker when the field signal toggles.

These extra entries are only written in the gap between lines. While they are pending, `pix_ready` is held low and incoming pixels are held off.

Top module: `vcap_status_tagger`

## Requirements
- R1: Each entry is 36 bits: the code is in bits 35:32 and the data in bits 31:0. Bytes are packed little-endian, so the first byte of a word lands in bits 7:0.
- R2: The first word of a line in a lane carries code 0010. Every other word that is not the last carries code 0000.
- R3: The last word of a line in a lane carries an end code that gives its valid byte count: 0001 for 4 bytes, 1101 for 3, 1001 for 2 and 0101 for 1. Unused upper bytes read as zero.
- R4: A line whose lane holds only one word gets the end code with its byte count, not 0010.
- R5: At the start of a field with `cap_en` high, a format indicator is written: 0110 when packed data follows, 1110 when planar data follows. It carries zero data. Lane 0 gets two copies on consecutive cycles; lanes 1 and 2 get one copy, in the first of those cycles.
- R6: A format indicator is also written when `cap_en` rises, and when the effective format changes while `cap_en` is high. A VBI line with `vbi_en` high counts as packed.
- R7: When `field_odd` toggles after a field in which a format indicator was written, all three lanes get a zero-data entry. Its code is 0100 if `field_odd` fell and 1100 if it rose.
- R8: Bytes are ignored, and produce no entry, when `cap_en` is low, when `line_active` is low, or on a VBI line with `vbi_en` low.
- R9: In planar format, the byte positions in a line cycle through lanes 0, 1, 0, 2, and the position restarts at every line. In packed format all bytes go to lane 0.
- R10: `pix_ready` is low in the cycle after a capture or field event. It stays low until the inserted entries are written, and no byte is taken while it is low.
- R11: A line end and a field toggle in the same cycle produce, per lane, the line's last word first, then the field-end entry, then the format indicator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Capture enable |
| fmt_planar | input | 1 | 1 = planar format, 0 = packed |
| field_odd | input | 1 | Field signal, high during the odd field |
| vbi_en | input | 1 | Allow capture of VBI lines |
| vbi_line | input | 1 | Current line is a VBI line |
| line_active | input | 1 | Active part of a scan line |
| pix_valid | input | 1 | `pix_data` carries a byte |
| pix_data | input | 8 | Pixel byte |
| pix_ready | output | 1 | Block can take a byte this cycle |
| lane_wr | output | 3 | Write strobe per lane |
| lane_data | output | 108 | 36-bit entry per lane; lane i is bits 36*i+35 down to 36*i |

## Verification
The closing word of a line and a field-end marker both want lane 0 at the moment a line ends exactly when `field_odd` toggles. The bench provokes this by dropping `line_active` and toggling the field on the same clock edge, both in a directed case and at random. It then compares every lane's entry sequence in order against a reference model. That model expects the end-of-line word first, then the field-end entry, then the format indicator, so an entry that is lost or reordered is reported as a mismatch.

// File: rtl/vst_pkg.sv
package vst_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int CODE_W     = 4;
    localparam int ENTRY_W    = WORD_W + CODE_W;
    localparam int NLANE      = 3;
    localparam int CNT_W      = $clog2(WORD_BYTES + 1);
    localparam int POS_W      = 2;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t C_FMT_PACKED = 4'b0110;
    localparam code_t C_FMT_PLANAR = 4'b1110;
    localparam code_t C_LINE_FIRST = 4'b0010;
    localparam code_t C_MIDDLE     = 4'b0000;
    localparam code_t C_END_FALL   = 4'b0100;
    localparam code_t C_END_RISE   = 4'b1100;

    // End-of-line code carrying the number of valid bytes of the last word.
    function automatic code_t eol_code(input logic [CNT_W-1:0] n);
        code_t c;
        case (n)
            CNT_W'(1): c = 4'b0101;
            CNT_W'(2): c = 4'b1001;
            CNT_W'(3): c = 4'b1101;
            default:   c = 4'b0001;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/vst_lane_packer.sv
module vst_lane_packer
    import vst_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_vld,
    input  logic [BYTE_W-1:0]  byte_in,
    input  logic               flush,
    output logic               wr,
    output logic [ENTRY_W-1:0] wdata
);
    typedef struct packed {
        logic [WORD_W-1:0]  acc;
        logic [CNT_W-1:0]   cnt;
        logic               first;
        logic               wr;
        logic [ENTRY_W-1:0] wdata;
    } pk_s;

    localparam pk_s PK_RST = '{acc: '0, cnt: '0, first: 1'b1, wr: 1'b0, wdata: '0};

    pk_s s_d, s_q;

    // A full word is held back until the next byte or the line end,
    // so that the last word of a line can still take its end code.
    always_comb begin
        s_d    = s_q;
        s_d.wr = 1'b0;
        if (flush) begin
            if (s_q.cnt != '0) begin
                s_d.wr    = 1'b1;
                s_d.wdata = {eol_code(s_q.cnt), s_q.acc};
            end
            s_d.acc   = '0;
            s_d.cnt   = '0;
            s_d.first = 1'b1;
        end else if (byte_vld) begin
            if (s_q.cnt == CNT_W'(WORD_BYTES)) begin
                s_d.wr                 = 1'b1;
                s_d.wdata              = {(s_q.first ? C_LINE_FIRST : C_MIDDLE), s_q.acc};
                s_d.first              = 1'b0;
                s_d.acc                = '0;
                s_d.acc[BYTE_W-1:0]    = byte_in;
                s_d.cnt                = CNT_W'(1);
            end else begin
                s_d.acc[int'(s_q.cnt)*BYTE_W +: BYTE_W] = byte_in;
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= PK_RST;
        else        s_q <= s_d;
    end

    assign wr    = s_q.wr;
    assign wdata = s_q.wdata;
endmodule

// File: rtl/vst_byte_router.sv
module vst_byte_router
    import vst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             planar,
    input  logic             flush,
    output logic [NLANE-1:0] lane_vld
);
    logic [POS_W-1:0] pos_d, pos_q;

    always_comb begin
        lane_vld = '0;
        if (take) begin
            if (!planar) begin
                lane_vld[0] = 1'b1;
            end else begin
                case (pos_q)
                    POS_W'(1): lane_vld[1] = 1'b1;
                    POS_W'(3): lane_vld[2] = 1'b1;
                    default:   lane_vld[0] = 1'b1;
                endcase
            end
        end
        if (flush)     pos_d = '0;
        else if (take) pos_d = pos_q + POS_W'(1);
        else           pos_d = pos_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end
endmodule

// File: rtl/vst_event_ctrl.sv
module vst_event_ctrl
    import vst_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_en,
    input  logic               field_odd,
    input  logic               line_active,
    input  logic               fmt_planar,
    input  logic               vbi_line,
    input  logic               vbi_en,
    input  logic               pix_valid,
    output logic               flush,
    output logic               take,
    output logic               planar_q,
    output logic               pix_ready,
    output logic [NLANE-1:0]   ins_wr,
    output logic [ENTRY_W-1:0] ins_data
);
    typedef struct packed {
        logic               cap;
        logic               fld;
        logic               line;
        logic               fmt_pl;
        logic               pend_mode;
        logic               pend_end;
        logic               mode2;
        logic               fld_cap;
        logic               ready;
        code_t              end_code;
        code_t              mode_code;
        logic [NLANE-1:0]   ins_wr;
        logic [ENTRY_W-1:0] ins_data;
    } ctl_s;

    localparam ctl_s CTL_RST = '{cap: 1'b0, fld: 1'b0, line: 1'b0, fmt_pl: 1'b0,
                                 pend_mode: 1'b0, pend_end: 1'b0, mode2: 1'b0,
                                 fld_cap: 1'b0, ready: 1'b1, end_code: '0,
                                 mode_code: '0, ins_wr: '0, ins_data: '0};

    ctl_s s_d, s_q;
    logic fmt_eff, fld_edge, cap_rise, fmt_chg, blocked, gap;

    always_comb begin
        fmt_eff  = (vbi_line && vbi_en) ? 1'b0 : fmt_planar;
        fld_edge = (field_odd != s_q.fld);
        cap_rise = cap_en && !s_q.cap;
        fmt_chg  = (fmt_eff != s_q.fmt_pl);
        blocked  = fld_edge || cap_rise || fmt_chg || (vbi_line && !vbi_en);
        flush    = s_q.line && !line_active;
        gap      = !line_active && !s_q.line;
        take     = pix_valid && line_active && cap_en && s_q.ready && !blocked;

        s_d          = s_q;
        s_d.cap      = cap_en;
        s_d.fld      = field_odd;
        s_d.line     = line_active;
        s_d.fmt_pl   = fmt_eff;
        s_d.ins_wr   = '0;
        s_d.ins_data = '0;

        // Inserted entries only go out between lines, never beside a flush.
        if (s_q.mode2) begin
            s_d.ins_wr    = NLANE'(1);
            s_d.ins_data  = {s_q.mode_code, {WORD_W{1'b0}}};
            s_d.mode2     = 1'b0;
        end else if (gap && s_q.pend_end) begin
            s_d.ins_wr    = '1;
            s_d.ins_data  = {s_q.end_code, {WORD_W{1'b0}}};
            s_d.pend_end  = 1'b0;
        end else if (gap && s_q.pend_mode) begin
            s_d.mode_code = s_q.fmt_pl ? C_FMT_PLANAR : C_FMT_PACKED;
            s_d.ins_wr    = '1;
            s_d.ins_data  = {s_d.mode_code, {WORD_W{1'b0}}};
            s_d.mode2     = 1'b1;
            s_d.pend_mode = 1'b0;
            s_d.fld_cap   = 1'b1;
        end

        if (fld_edge) begin
            if (s_q.fld_cap) begin
                s_d.pend_end = 1'b1;
                s_d.end_code = s_q.fld ? C_END_FALL : C_END_RISE;
            end
            s_d.fld_cap = 1'b0;
        end
        if ((fld_edge && cap_en) || cap_rise || (fmt_chg && cap_en))
            s_d.pend_mode = 1'b1;

        s_d.ready = !s_d.pend_mode && !s_d.pend_end && !s_d.mode2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= CTL_RST;
        else        s_q <= s_d;
    end

    assign planar_q  = s_q.fmt_pl;
    assign pix_ready = s_q.ready;
    assign ins_wr    = s_q.ins_wr;
    assign ins_data  = s_q.ins_data;
endmodule

// File: rtl/vcap_status_tagger.sv
module vcap_status_tagger
    import vst_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_en,
    input  logic                     fmt_planar,
    input  logic                     field_odd,
    input  logic                     vbi_en,
    input  logic                     vbi_line,
    input  logic                     line_active,
    input  logic                     pix_valid,
    input  logic [BYTE_W-1:0]        pix_data,
    output logic                     pix_ready,
    output logic [NLANE-1:0]         lane_wr,
    output logic [NLANE*ENTRY_W-1:0] lane_data
);
    logic               flush, take, planar_q;
    logic [NLANE-1:0]   ins_wr, lane_vld, pk_wr;
    logic [ENTRY_W-1:0] ins_data;
    logic [ENTRY_W-1:0] pk_data [NLANE];

    vst_event_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .field_odd(field_odd),
        .line_active(line_active), .fmt_planar(fmt_planar), .vbi_line(vbi_line),
        .vbi_en(vbi_en), .pix_valid(pix_valid), .flush(flush), .take(take),
        .planar_q(planar_q), .pix_ready(pix_ready), .ins_wr(ins_wr), .ins_data(ins_data)
    );

    vst_byte_router u_route (
        .clk(clk), .rst_n(rst_n), .take(take), .planar(planar_q),
        .flush(flush), .lane_vld(lane_vld)
    );

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        vst_lane_packer u_pack (
            .clk(clk), .rst_n(rst_n), .byte_vld(lane_vld[i]), .byte_in(pix_data),
            .flush(flush), .wr(pk_wr[i]), .wdata(pk_data[i])
        );
        assign lane_wr[i] = pk_wr[i] | ins_wr[i];
        assign lane_data[i*ENTRY_W +: ENTRY_W] = ins_wr[i] ? ins_data : pk_data[i];
    end
endmodule

// File: rtl/vst_tagger_chk.sv
module vst_tagger_chk
    import vst_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cap_en,
    input logic                     pix_ready,
    input logic [NLANE-1:0]         lane_wr,
    input logic [NLANE*ENTRY_W-1:0] lane_data
);
    code_t c0;
    logic  fmt0, ins0;
    assign c0   = lane_data[ENTRY_W-1 -: CODE_W];
    assign fmt0 = lane_wr[0] && (c0 == C_FMT_PACKED || c0 == C_FMT_PLANAR);
    assign ins0 = fmt0 || (lane_wr[0] && (c0 == C_END_FALL || c0 == C_END_RISE));

    // R5
    mode_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt0 && lane_wr == '1) |=> (lane_wr == NLANE'(1) &&
            lane_data[ENTRY_W-1:0] == $past(lane_data[ENTRY_W-1:0])));

    // R7
    ctrl_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins0 |-> lane_data[WORD_W-1:0] == '0);

    // R3
    eol_one_byte_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_wr[0] && c0 == 4'b0101) |-> lane_data[WORD_W-1:BYTE_W] == '0);

    // R10
    hold_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_en) |=> !pix_ready);

    // R10
    insert_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins0 |-> $past(!pix_ready));
endmodule

bind vcap_status_tagger vst_tagger_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .pix_ready(pix_ready),
    .lane_wr(lane_wr), .lane_data(lane_data)
);

// File: tb/vcap_status_tagger_tb.sv
module vcap_status_tagger_tb;
    import vst_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap_en = 1'b0, fmt_planar = 1'b0, field_odd = 1'b0;
    logic vbi_en = 1'b0, vbi_line = 1'b0, line_active = 1'b0, pix_valid = 1'b0;
    logic [7:0] pix_data = '0;
    logic pix_ready;
    logic [2:0] lane_wr;
    logic [107:0] lane_data;

    always #4 clk = ~clk;

    vcap_status_tagger u_dut (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .fmt_planar(fmt_planar),
        .field_odd(field_odd), .vbi_en(vbi_en), .vbi_line(vbi_line),
        .line_active(line_active), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_ready(pix_ready), .lane_wr(lane_wr), .lane_data(lane_data)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    bit m_fld_cap = 1'b0;
    logic [35:0] eq0[$], eq1[$], eq2[$];
    string tq0[$], tq1[$], tq2[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push(input int ln, input logic [35:0] e, input string t);
        case (ln)
            0: begin eq0.push_back(e); tq0.push_back(t); end
            1: begin eq1.push_back(e); tq1.push_back(t); end
            default: begin eq2.push_back(e); tq2.push_back(t); end
        endcase
    endtask

    task automatic mon_lane(input int ln, input logic [35:0] got);
        logic [35:0] e = '0;
        string t = "";
        bit have = 1'b0;
        case (ln)
            0: if (eq0.size() > 0) begin have = 1; e = eq0.pop_front(); t = tq0.pop_front(); end
            1: if (eq1.size() > 0) begin have = 1; e = eq1.pop_front(); t = tq1.pop_front(); end
            default: if (eq2.size() > 0) begin have = 1; e = eq2.pop_front(); t = tq2.pop_front(); end
        endcase
        if (!have) check(1'b0, "R8", $sformatf("unexpected write lane %0d", ln), 64'(got), 64'd0);
        else       check(got == e, t, $sformatf("lane %0d entry", ln), 64'(got), 64'(e));
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 3; i++)
                if (lane_wr[i]) mon_lane(i, lane_data[i*36 +: 36]);
        end
    end

    function automatic bit eff_planar();
        return (vbi_line && vbi_en) ? 1'b0 : fmt_planar;
    endfunction

    function automatic logic [3:0] eol_exp(input int n);
        case (n)
            1: return 4'b0101;
            2: return 4'b1001;
            3: return 4'b1101;
            default: return 4'b0001;
        endcase
    endfunction

    task automatic push_mode(input string t);
        logic [3:0] c = eff_planar() ? 4'b1110 : 4'b0110;
        push(0, {c, 32'd0}, t);
        push(0, {c, 32'd0}, t);
        push(1, {c, 32'd0}, t);
        push(2, {c, 32'd0}, t);
        m_fld_cap = 1'b1;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    // R7 / R5: field toggle applied at the current negedge, no waiting.
    task automatic field_now();
        if (m_fld_cap) begin
            logic [3:0] c = field_odd ? 4'b0100 : 4'b1100;
            for (int l = 0; l < 3; l++) push(l, {c, 32'd0}, "R7");
        end
        m_fld_cap = 1'b0;
        field_odd = ~field_odd;
        if (cap_en) push_mode("R5");
    endtask

    task automatic set_cap(input bit v);
        if (v && !cap_en) push_mode("R6");
        cap_en = v;
        settle();
    endtask

    task automatic set_fmt(input bit pl, input bit vl, input bit ve);
        bit old = eff_planar();
        fmt_planar = pl; vbi_line = vl; vbi_en = ve;
        if (eff_planar() != old && cap_en) push_mode("R6");
        settle();
    endtask

    task automatic pack_lane(input int ln, input byte unsigned q[$]);
        int n = q.size();
        int nw = (n + 3) / 4;
        for (int w = 0; w < nw; w++) begin
            logic [31:0] d = '0;
            int cnt = 0;
            logic [3:0] c;
            string t;
            for (int k = 0; k < 4; k++) begin
                if (w*4 + k < n) begin
                    d[k*8 +: 8] = q[w*4 + k];
                    cnt++;
                end
            end
            if (w == nw - 1) begin
                c = eol_exp(cnt);
                t = (nw == 1) ? "R4" : "R3";
            end else begin
                c = (w == 0) ? 4'b0010 : 4'b0000;
                t = "R2";
            end
            if (ln != 0) t = {t, "/R9"};
            push(ln, {c, d}, t);
        end
    endtask

    task automatic model_line(input byte unsigned b[$], input bit pl);
        byte unsigned l0[$], l1[$], l2[$];
        for (int i = 0; i < b.size(); i++) begin
            if (!pl) l0.push_back(b[i]);
            else case (i % 4)
                1: l1.push_back(b[i]);
                3: l2.push_back(b[i]);
                default: l0.push_back(b[i]);
            endcase
        end
        pack_lane(0, l0);
        pack_lane(1, l1);
        pack_lane(2, l2);
    endtask

    task automatic drive_line(input int n, input bit conflict);
        byte unsigned b[$];
        int i = 0;
        for (int k = 0; k < n; k++) b.push_back(8'($urandom));
        if (cap_en && !(vbi_line && !vbi_en)) model_line(b, eff_planar());
        line_active = 1'b1;
        while (i < n) begin
            if (($urandom % 4) == 0) begin
                pix_valid = 1'b0;
            end else begin
                pix_valid = 1'b1;
                pix_data  = b[i];
                if (pix_ready) i++;
            end
            @(negedge clk);
        end
        pix_valid   = 1'b0;
        line_active = 1'b0;
        if (conflict) field_now();   // R11: line end and field edge together
        settle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(lane_wr == 3'b000, "R10", "no write after reset", 64'(lane_wr), 64'd0);
        check(pix_ready == 1'b1, "R10", "ready after reset", 64'(pix_ready), 64'd1);

        // R8: bytes with capture off, and bytes outside the line, are dropped
        drive_line(9, 1'b0);
        cap_en = 1'b0;
        pix_valid = 1'b1;
        repeat (5) @(negedge clk);
        pix_valid = 1'b0;
        check(lane_wr == 3'b000, "R8", "no write for idle bytes", 64'(lane_wr), 64'd0);

        // R6 / R10: capture switched on mid-field
        push_mode("R6");
        cap_en = 1'b1;
        @(negedge clk);
        check(pix_ready == 1'b0, "R10", "held after capture on", 64'(pix_ready), 64'd0);
        repeat (2) @(negedge clk);
        check(pix_ready == 1'b1, "R10", "released after indicator", 64'(pix_ready), 64'd1);
        settle();

        // R1-style packed lines, R3 byte counts, R4 single word
        drive_line(1, 1'b0);
        drive_line(4, 1'b0);
        drive_line(5, 1'b0);
        drive_line(11, 1'b0);
        drive_line(3, 1'b0);

        // R7 / R5: field edge with capture on
        field_now();
        settle();

        // R6 / R9: planar
        set_fmt(1'b1, 1'b0, 1'b0);
        drive_line(2, 1'b0);
        drive_line(7, 1'b0);
        drive_line(16, 1'b0);
        drive_line(13, 1'b0);

        // R8: VBI line with VBI capture off; R6: VBI line captured packed
        set_fmt(1'b1, 1'b1, 1'b0);
        drive_line(6, 1'b0);
        set_fmt(1'b1, 1'b1, 1'b1);
        drive_line(9, 1'b0);
        set_fmt(1'b1, 1'b0, 1'b1);
        drive_line(10, 1'b0);

        // R11: line end together with field edge
        drive_line(10, 1'b1);

        // R7: field end with capture off, then an uncaptured field
        set_cap(1'b0);
        field_now();
        settle();
        field_now();
        settle();
        set_cap(1'b1);

        for (int it = 0; it < 60; it++) begin
            case ($urandom % 9)
                0: set_fmt(~fmt_planar, vbi_line, vbi_en);
                1: set_fmt(fmt_planar, ~vbi_line, vbi_en);
                2: set_fmt(fmt_planar, vbi_line, ~vbi_en);
                3: set_cap(~cap_en);
                4: begin field_now(); settle(); end
                default: drive_line(1 + int'($urandom % 24), ($urandom % 5) == 0);
            endcase
        end

        settle();
        check(eq0.size() == 0, "R5", "lane 0 entries left", 64'(eq0.size()), 64'd0);
        check(eq1.size() == 0, "R9", "lane 1 entries left", 64'(eq1.size()), 64'd0);
        check(eq2.size() == 0, "R9", "lane 2 entries left", 64'(eq2.size()), 64'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule